// File: doc/BRIEF.md
# Dual-Field Carry-Lookahead Adder

This block is a purely combinational adder of parameterised width that serves two kinds of arithmetic from one carry tree. With the field-select input high it adds two unsigned integers plus a carry-in and reports the carry-out. With the field-select input low it adds two binary polynomials over GF(2), which means every carry is suppressed and each result bit is simply the exclusive-OR of the matching operand bits.

Carries are formed by a three-level lookahead hierarchy built from identical 4-bit lookahead generators: bit cells feed 4-bit groups, groups feed 16-bit sections, and sections feed 64-bit blocks. Blocks beyond the first are chained serially. The field-select line gates each bit's generate term, its carry-propagate term and the incoming carry, so in polynomial mode the entire tree evaluates to zero. The block has no clock and no state; it is intended as the addition stage inside a wider dual-field datapath.

Top module: `dual_field_cla`

## Requirements
- R1: With fsel_i = 1 (integer mode), {cout_o, sum_o} equals the exact (WIDTH+1)-bit value of a_i + b_i + cin_i.
- R2: With fsel_i = 0 (polynomial mode), sum_o equals a_i XOR b_i bit by bit.
- R3: With fsel_i = 0, cout_o is 0 for every operand pair.
- R4: With fsel_i = 0, cin_i has no effect: sum_o and cout_o are the same for cin_i = 0 and cin_i = 1.
- R5: In integer mode a carry-in entering an all-ones operand added to zero travels the full width, giving sum_o = 0 and cout_o = 1.
- R6: In integer mode a carry produced below any 4-bit group boundary, 16-bit section boundary or the top bit reaches the next position correctly (for a_i = 2^k - 1, b_i = 1, cin_i = 0 the result is 2^k).
- R7: With fsel_i = 0, positions where both operand bits are 1 generate no carry: all-ones plus all-ones yields sum_o = 0 and cout_o = 0.
- R8: The outputs are a function of the present inputs only: changing fsel_i with the operands held changes the result without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (integer or GF(2) polynomial coefficients) |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in, used in integer mode only |
| fsel_i | input | 1 | Field select: 1 = integer addition, 0 = GF(2) addition |
| sum_o | output | WIDTH | Sum |
| cout_o | output | 1 | Carry-out, 0 in polynomial mode |

## Verification
Because the block holds no state, a wrong internal carry appears at the ports at once, in the same evaluation as the input change that provoked it. A stuck or ungated generate term shows as a flipped sum bit in polynomial mode wherever both operands are 1, while a broken lookahead term at one hierarchy level shows only for operands whose carry crosses that particular group or section boundary, which is why directed boundary operands are applied in addition to scattered values. A leak of the carry-in into the tree in polynomial mode shows as a flipped low sum bit or a nonzero carry-out.

// File: rtl/dfa_pkg.sv
`timescale 1ns/1ps
package dfa_pkg;

  localparam int unsigned GRP = 4;

  // Carry into each position of a 4-bit group, position 0 being the group carry-in.
  // Written as a sum of products so it maps onto an AND-OR network.
  function automatic logic [3:0] grp_carries(input logic [3:0] g, input logic [3:0] p,
                                             input logic cin);
    logic [3:0] c;
    logic       term;
    c[0] = cin;
    for (int i = 1; i < 4; i++) begin
      c[i] = 1'b0;
      for (int k = 0; k < i; k++) begin
        term = g[k];
        for (int m = k + 1; m < i; m++) term = term & p[m];
        c[i] = c[i] | term;
      end
      term = cin;
      for (int m = 0; m < i; m++) term = term & p[m];
      c[i] = c[i] | term;
    end
    return c;
  endfunction

  // Group generate: the group produces a carry regardless of its carry-in.
  function automatic logic grp_generate(input logic [3:0] g, input logic [3:0] p);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int k = 0; k < 4; k++) begin
      term = g[k];
      for (int m = k + 1; m < 4; m++) term = term & p[m];
      acc = acc | term;
    end
    return acc;
  endfunction

  // Group propagate: an incoming carry passes through every position.
  function automatic logic grp_propagate(input logic [3:0] p);
    return &p;
  endfunction

endpackage

// File: rtl/dfa_pg_cell.sv
`timescale 1ns/1ps
module dfa_pg_cell #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             fsel_i,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] prop_o,
  output logic [WIDTH-1:0] half_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign half_o[i] = a_i[i] ^ b_i[i];
    assign gen_o[i]  = fsel_i & a_i[i] & b_i[i];
    assign prop_o[i] = fsel_i & half_o[i];
  end

  // R7: with the polynomial field selected no position may generate or pass a carry,
  // even where both operand bits are set.
  always_comb begin
    if (!fsel_i) begin
      p_gen_gated_r7 : assert ((gen_o == '0) && (prop_o == '0))
        else $error("generate/propagate active in polynomial mode");
    end
  end

endmodule

// File: rtl/dfa_lookahead_gen.sv
`timescale 1ns/1ps
module dfa_lookahead_gen
  import dfa_pkg::*;
(
  input  logic [3:0] g_i,
  input  logic [3:0] p_i,
  input  logic       cin_i,
  output logic [3:0] c_o,
  output logic       gg_o,
  output logic       gp_o
);

  assign c_o  = grp_carries(g_i, p_i, cin_i);
  assign gg_o = grp_generate(g_i, p_i);
  assign gp_o = grp_propagate(p_i);

  // R1: propagate uses the exclusive-OR half sum, so a group that passes every
  // carry cannot also create one; both set means a corrupted term below.
  always_comb begin
    p_gp_exclusive_r1 : assert (!(gg_o && gp_o))
      else $error("group both generates and propagates");
  end

endmodule

// File: rtl/dfa_cla_tree.sv
`timescale 1ns/1ps
module dfa_cla_tree #(
  parameter int unsigned NBITS = 64
) (
  input  logic [NBITS-1:0] gen_i,
  input  logic [NBITS-1:0] prop_i,
  input  logic             cin_i,
  output logic [NBITS-1:0] carry_o,
  output logic             cout_o
);

  localparam int unsigned N1 = NBITS / 4;          // 4-bit groups
  localparam int unsigned N2 = (N1 + 3) / 4;       // 16-bit sections
  localparam int unsigned N3 = (N2 + 3) / 4;       // 64-bit blocks
  localparam int unsigned PB = N3 * 64;            // padded width
  localparam int unsigned NG = N3 * 16;            // padded group count
  localparam int unsigned NS = N3 * 4;             // padded section count

  logic [PB-1:0] g_pad, p_pad, c_bit;
  logic [NG-1:0] g_l1, p_l1, c_l1;
  logic [NS-1:0] g_l2, p_l2, c_l2;
  logic [N3-1:0] g_l3, p_l3, c_l3;

  if (PB > NBITS) begin : g_pad_fill
    assign g_pad = {{(PB-NBITS){1'b0}}, gen_i};
    assign p_pad = {{(PB-NBITS){1'b0}}, prop_i};
  end else begin : g_pad_none
    assign g_pad = gen_i;
    assign p_pad = prop_i;
  end

  // Level 1: bit carries inside each 4-bit group
  for (genvar j = 0; j < NG; j++) begin : g_lvl1
    dfa_lookahead_gen u_clg (
      .g_i   (g_pad[4*j +: 4]),
      .p_i   (p_pad[4*j +: 4]),
      .cin_i (c_l1[j]),
      .c_o   (c_bit[4*j +: 4]),
      .gg_o  (g_l1[j]),
      .gp_o  (p_l1[j])
    );
  end

  // Level 2: group carries inside each 16-bit section
  for (genvar k = 0; k < NS; k++) begin : g_lvl2
    dfa_lookahead_gen u_clg (
      .g_i   (g_l1[4*k +: 4]),
      .p_i   (p_l1[4*k +: 4]),
      .cin_i (c_l2[k]),
      .c_o   (c_l1[4*k +: 4]),
      .gg_o  (g_l2[k]),
      .gp_o  (p_l2[k])
    );
  end

  // Level 3: section carries inside each 64-bit block
  for (genvar m = 0; m < N3; m++) begin : g_lvl3
    dfa_lookahead_gen u_clg (
      .g_i   (g_l2[4*m +: 4]),
      .p_i   (p_l2[4*m +: 4]),
      .cin_i (c_l3[m]),
      .c_o   (c_l2[4*m +: 4]),
      .gg_o  (g_l3[m]),
      .gp_o  (p_l3[m])
    );
  end

  // Blocks above the first are chained serially
  assign c_l3[0] = cin_i;
  for (genvar m = 1; m < N3; m++) begin : g_block_chain
    assign c_l3[m] = g_l3[m-1] | (p_l3[m-1] & c_l3[m-1]);
  end

  assign carry_o = c_bit[NBITS-1:0];
  assign cout_o  = g_l1[N1-1] | (p_l1[N1-1] & c_l1[N1-1]);

  // R1: the block-level chain out of the last block must agree with the carry-out
  // taken from the last real group; padded positions never hold a generated carry.
  logic last_blk_out;
  assign last_blk_out = g_l3[N3-1] | (p_l3[N3-1] & c_l3[N3-1]);

  if (PB > NBITS) begin : g_pad_chk
    always_comb begin
      p_pad_carry_r1 : assert ((c_bit[NBITS] == cout_o) && (last_blk_out == 1'b0))
        else $error("carry into padding disagrees with carry-out");
      if (PB > NBITS + 1) begin
        p_pad_quiet_r1 : assert (c_bit[PB-1:NBITS+1] == '0)
          else $error("carry inside padding");
      end
    end
  end else begin : g_full_chk
    always_comb begin
      p_block_cout_r1 : assert (last_blk_out == cout_o)
        else $error("block chain carry-out disagrees with group carry-out");
    end
  end

endmodule

// File: rtl/dual_field_cla.sv
`timescale 1ns/1ps
module dual_field_cla #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic             fsel_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH-1:0] bit_gen, bit_prop, half_sum, carry_vec;
  logic             cin_gated;

  assign cin_gated = fsel_i & cin_i;

  dfa_pg_cell #(.WIDTH(WIDTH)) u_pg (
    .a_i    (a_i),
    .b_i    (b_i),
    .fsel_i (fsel_i),
    .gen_o  (bit_gen),
    .prop_o (bit_prop),
    .half_o (half_sum)
  );

  dfa_cla_tree #(.NBITS(WIDTH)) u_tree (
    .gen_i   (bit_gen),
    .prop_i  (bit_prop),
    .cin_i   (cin_gated),
    .carry_o (carry_vec),
    .cout_o  (cout_o)
  );

  assign sum_o = half_sum ^ carry_vec;

  // Guards against the operand ports, independent of the carry tree
  logic [WIDTH:0] int_ref;
  assign int_ref = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    if (fsel_i) begin
      p_int_exact_r1 : assert ({cout_o, sum_o} == int_ref)
        else $error("integer sum mismatch");
    end else begin
      p_gf_xor_r2 : assert (sum_o == (a_i ^ b_i))
        else $error("polynomial sum is not XOR");
      p_gf_cout_r3 : assert (cout_o == 1'b0)
        else $error("carry-out in polynomial mode");
      p_gf_cin_ignored_r4 : assert (carry_vec == '0)
        else $error("carry reached tree in polynomial mode");
    end
  end

endmodule

// File: tb/dual_field_cla_tb.sv
`timescale 1ns/1ps
module dual_field_cla_tb;

  localparam int unsigned W = 64;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic         cin, fsel;
  logic [W-1:0] sum;
  logic         cout;

  int n_checks = 0;
  int n_fail   = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #5 clk = ~clk;

  dual_field_cla #(.WIDTH(W)) u_dut (
    .a_i(a), .b_i(b), .cin_i(cin), .fsel_i(fsel), .sum_o(sum), .cout_o(cout)
  );

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb_,
                       input logic tc, input logic tf);
    @(negedge clk);
    a = ta; b = tb_; cin = tc; fsel = tf;
    #2;
  endtask

  function automatic logic [W:0] int_expect(input logic [W-1:0] x, input logic [W-1:0] y,
                                            input logic c);
    logic [W:0] r;
    r = {1'b0, x};
    r = r + {1'b0, y};
    if (c) r = r + 1;
    return r;
  endfunction

  task automatic t_idle;
    apply('0, '0, 1'b0, 1'b1);
    check("R1 zero inputs", {cout, sum}, '0);
  endtask

  task automatic t_int_scatter;
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] x, y;
      seed = next_rand(seed); x = seed;
      seed = next_rand(seed); y = seed;
      apply(x, y, seed[3], 1'b1);
      check("R1 integer sum", {cout, sum}, int_expect(x, y, seed[3]));
    end
  endtask

  task automatic t_gf_scatter;
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] x, y;
      seed = next_rand(seed); x = seed;
      seed = next_rand(seed); y = seed;
      apply(x, y, seed[5], 1'b0);
      begin
        logic [W-1:0] e;
        e = '0;
        for (int k = 0; k < W; k++) e[k] = (x[k] != y[k]);
        check("R2 polynomial sum", {1'b0, sum}, {1'b0, e});
      end
      check("R3 polynomial carry-out", {{W{1'b0}}, cout}, '0);
    end
  endtask

  task automatic t_gf_cin;
    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] x, y, s0;
      logic         c0;
      seed = next_rand(seed); x = seed;
      seed = next_rand(seed); y = (i == 0) ? ~x : seed;
      apply(x, y, 1'b0, 1'b0);
      s0 = sum; c0 = cout;
      apply(x, y, 1'b1, 1'b0);
      check("R4 carry-in ignored", {cout, sum}, {c0, s0});
    end
  endtask

  task automatic t_full_ripple;
    apply('1, '0, 1'b1, 1'b1);
    check("R5 full-width ripple", {cout, sum}, {1'b1, {W{1'b0}}});
    apply('0, '1, 1'b1, 1'b1);
    check("R5 full-width ripple swapped", {cout, sum}, {1'b1, {W{1'b0}}});
  endtask

  task automatic t_boundaries;
    int ks[8] = '{4, 8, 16, 20, 32, 48, 60, 63};
    foreach (ks[i]) begin
      logic [W-1:0] x;
      logic [W:0]   e;
      x = '0;
      for (int k = 0; k < ks[i]; k++) x[k] = 1'b1;
      e = '0; e[ks[i]] = 1'b1;
      apply(x, {{(W-1){1'b0}}, 1'b1}, 1'b0, 1'b1);
      check("R6 boundary carry", {cout, sum}, e);
    end
    apply({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0, 1'b1);
    check("R6 top-bit carry-out", {cout, sum}, {1'b1, {W{1'b0}}});
  endtask

  task automatic t_gf_all_ones;
    apply('1, '1, 1'b1, 1'b0);
    check("R7 no generate in polynomial mode", {cout, sum}, '0);
  endtask

  task automatic t_mode_switch;
    logic [W-1:0] x, y;
    x = 64'h0F0F_FFFF_0000_8001;
    y = 64'h0101_0001_FFFF_7FFF;
    apply(x, y, 1'b1, 1'b1);
    check("R8 integer before switch", {cout, sum}, int_expect(x, y, 1'b1));
    @(posedge clk); #2;
    fsel = 1'b0;
    #1;
    check("R8 polynomial after switch without edge", {cout, sum}, {1'b0, x ^ y});
    fsel = 1'b1;
    #1;
    check("R8 integer after switch back", {cout, sum}, int_expect(x, y, 1'b1));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    a = '0; b = '0; cin = 1'b0; fsel = 1'b1;
    t_idle();
    t_int_scatter();
    t_gf_scatter();
    t_gf_cin();
    t_full_ripple();
    t_boundaries();
    t_gf_all_ones();
    t_mode_switch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule